// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit carries out one atomic operation at a time on a single cached block. Each operation is one of test-and-set, compare-and-swap, fetch-and-add, or a plain atomic read. The block lives in a one-line cache model that takes part in an M/S/I protocol. A line in S may only be read. A line in M may be read and written. Atomicity rests on coherence permission and not on a bus lock. The unit first waits for older buffered stores to drain. It then obtains M for the target address, issuing GetM if it has to. It reads and writes the line in two consecutive cycles and refuses incoming coherence requests from the read through the write.

Each operation passes through six phases in a fixed order: idle, drain, acquire, read, write and respond. A held-off request from another agent is taken in the respond cycle, which is the cycle straight after the write. Requests taken one at a time on the single request port are therefore served in the order they arrive. When the unit takes over a new address while its line holds dirty data for another address, the dirty data leaves with the GetM request.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Kind 2'b00 (test-and-set) returns the block's old value and leaves the value 1 in it.
- R2: Kind 2'b01 (compare-and-swap) returns the old value and writes `op_arg_b` only when the old value equals `op_arg_a`; otherwise the block keeps its value.
- R3: Kind 2'b10 (fetch-and-add) returns the old value and stores old + `op_arg_a` modulo 2^DW.
- R4: Kind 2'b11 returns the old value and leaves the block unchanged.
- R5: After an operation is accepted, no GetM and no response appear while `wb_empty` is low.
- R6: If the line is not in M for the operation's address, `getm_valid` rises with `getm_addr` set to that address and stays high until `grant_valid`. The line then takes `grant_data` in state M. A dirty line for another address is shown on `evict_dirty`/`evict_addr`/`evict_data` while the request is up. If the line is already in M for that address, no GetM is issued.
- R7: `snp_ready` is low in the read and write cycles and high in the respond cycle, so a held-off request is taken right after the write.
- R8: An accepted request whose address matches a valid line invalidates it (`snp_getm`=1) or lowers M to S (`snp_getm`=0). `snp_ack` follows one cycle later, with `snp_dirty` set when the line was in M and `snp_data` holding its value. A request that does not match changes nothing.
- R9: `op_ready` is high only when idle. `resp_valid` is a one-cycle pulse carrying `resp_old` and the operation's `resp_dst`.
- R10: With the line in M for the address and `wb_empty` high, `resp_valid` is high after the fourth rising edge that follows the accepting edge. Each cycle of low `wb_empty` adds one cycle.
- R11: After reset the line is invalid, `op_ready` is high, and `resp_valid`, `getm_valid` and `snp_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Unit idle, request taken |
| op_kind | input | 2 | 00 TAS, 01 CAS, 10 FAA, 11 read |
| op_addr | input | AW | Block address |
| op_arg_a | input | DW | Compare value (CAS) or addend (FAA) |
| op_arg_b | input | DW | Swap value (CAS) |
| op_dst | input | TW | Destination tag |
| wb_empty | input | 1 | Older stores drained |
| resp_valid | output | 1 | Result pulse |
| resp_old | output | DW | Old block value |
| resp_dst | output | TW | Destination tag of the result |
| getm_valid | output | 1 | Outgoing GetM request |
| getm_addr | output | AW | GetM address |
| evict_dirty | output | 1 | Dirty victim travels with GetM |
| evict_addr | output | AW | Victim address |
| evict_data | output | DW | Victim data |
| grant_valid | input | 1 | GetM granted |
| grant_data | input | DW | Block data with the grant |
| snp_valid | input | 1 | Incoming coherence request |
| snp_ready | output | 1 | Incoming request taken |
| snp_getm | input | 1 | 1 GetM, 0 GetS |
| snp_addr | input | AW | Incoming request address |
| snp_ack | output | 1 | Incoming request answered |
| snp_dirty | output | 1 | Answer carries modified data |
| snp_data | output | DW | Line data in the answer |

## Verification
Vectors cover each operation kind on hits and on misses. They include a successful and a failing compare-and-swap, a fetch-and-add that wraps past 2^DW, and a miss that forces out a dirty block for another address, which separates eviction from a plain fill. Directed cases hold `wb_empty` low to tell draining apart from acquiring. They raise a GetS in mid-operation to show the lock window and the data handed over after the write. They then issue an atomic on an S line to show that S is not enough to write. Finally they send a GetM while idle, have another agent change the value, and compare that with a request for an unrelated address, which must leave the line in M.

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int TW = 5
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [1:0]    op_kind,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_arg_a,
  input  logic [DW-1:0] op_arg_b,
  input  logic [TW-1:0] op_dst,
  input  logic          wb_empty,
  output logic          resp_valid,
  output logic [DW-1:0] resp_old,
  output logic [TW-1:0] resp_dst,
  output logic          getm_valid,
  output logic [AW-1:0] getm_addr,
  output logic          evict_dirty,
  output logic [AW-1:0] evict_addr,
  output logic [DW-1:0] evict_data,
  input  logic          grant_valid,
  input  logic [DW-1:0] grant_data,
  input  logic          snp_valid,
  output logic          snp_ready,
  input  logic          snp_getm,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_ack,
  output logic          snp_dirty,
  output logic [DW-1:0] snp_data
);
  typedef enum logic [2:0] {IDLE, DRAIN, ACQUIRE, READ, WRITE, RESPOND} st_t;
  typedef enum logic [1:0] {LN_I, LN_S, LN_M} ln_t;

  st_t st, st_nx;
  ln_t ln_st;
  logic [AW-1:0] ln_tag, k_addr;
  logic [DW-1:0] ln_data, k_a, k_b, old_q, new_val;
  logic [1:0]    k_kind;
  logic [TW-1:0] k_dst;
  logic hit_m, snp_take, snp_match, fill;

  assign hit_m     = (ln_st == LN_M) && (ln_tag == k_addr);
  assign fill      = (st == ACQUIRE) && !hit_m && grant_valid;
  assign op_ready  = (st == IDLE);
  assign resp_valid = (st == RESPOND);
  assign resp_old  = old_q;
  assign resp_dst  = k_dst;

  assign getm_valid  = (st == ACQUIRE) && !hit_m;
  assign getm_addr   = k_addr;
  assign evict_dirty = getm_valid && (ln_st == LN_M);
  assign evict_addr  = ln_tag;
  assign evict_data  = ln_data;

  assign snp_ready = !((st == READ) || (st == WRITE) ||
                       ((st == ACQUIRE) && (hit_m || grant_valid)));
  assign snp_take  = snp_valid && snp_ready;
  assign snp_match = (ln_st != LN_I) && (ln_tag == snp_addr);

  always_comb begin
    case (k_kind)
      2'd0:    new_val = DW'(1);
      2'd1:    new_val = (old_q == k_a) ? k_b : old_q;
      2'd2:    new_val = old_q + k_a;
      default: new_val = old_q;
    endcase
  end

  always_comb begin
    st_nx = st;
    case (st)
      IDLE:    if (op_valid) st_nx = DRAIN;
      DRAIN:   if (wb_empty) st_nx = ACQUIRE;
      ACQUIRE: if (hit_m || grant_valid) st_nx = READ;
      READ:    st_nx = WRITE;
      WRITE:   st_nx = RESPOND;
      default: st_nx = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      k_kind <= '0;
      k_addr <= '0;
      k_a    <= '0;
      k_b    <= '0;
      k_dst  <= '0;
      old_q  <= '0;
    end else begin
      st <= st_nx;
      if (st == IDLE && op_valid) begin
        k_kind <= op_kind;
        k_addr <= op_addr;
        k_a    <= op_arg_a;
        k_b    <= op_arg_b;
        k_dst  <= op_dst;
      end
      if (st == READ) old_q <= ln_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ln_st   <= LN_I;
      ln_tag  <= '0;
      ln_data <= '0;
    end else if (fill) begin
      ln_st   <= LN_M;
      ln_tag  <= k_addr;
      ln_data <= grant_data;
    end else if (st == WRITE) begin
      ln_data <= new_val;
    end else if (snp_take && snp_match) begin
      if (snp_getm) ln_st <= LN_I;
      else if (ln_st == LN_M) ln_st <= LN_S;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snp_ack   <= 1'b0;
      snp_dirty <= 1'b0;
      snp_data  <= '0;
    end else begin
      snp_ack   <= snp_take;
      snp_dirty <= snp_take && snp_match && (ln_st == LN_M);
      snp_data  <= ln_data;
    end
  end
endmodule

// File: rtl/atomic_rmw_unit_chk.sv
module atomic_rmw_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic op_valid,
  input logic op_ready,
  input logic resp_valid,
  input logic getm_valid,
  input logic grant_valid,
  input logic snp_valid,
  input logic snp_ready,
  input logic snp_ack,
  input logic snp_dirty
);
  // R5
  drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> (!getm_valid && !resp_valid));
  // R6
  getm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (getm_valid && !grant_valid) |=> getm_valid);
  // R7
  lock_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(!snp_ready) && $past(!snp_ready, 2)));
  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> snp_ready);
  // R8
  snp_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_ready) |=> snp_ack);
  // R8
  dirty_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_dirty |-> snp_ack);
  // R9
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  // R9
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_ready, getm_valid, resp_valid}));
endmodule

bind atomic_rmw_unit atomic_rmw_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .resp_valid(resp_valid), .getm_valid(getm_valid), .grant_valid(grant_valid),
  .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_ack(snp_ack),
  .snp_dirty(snp_dirty)
);

// File: tb/atomic_rmw_unit_bench.sv
module atomic_rmw_unit_bench;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int TW = 5;
  localparam int NV = 10;

  // {kind, addr, a, b}
  localparam logic [67:0] VECS [NV] = '{
    {2'd0, 2'd0, 32'd0, 32'd0},
    {2'd0, 2'd0, 32'd0, 32'd0},
    {2'd1, 2'd1, 32'd7, 32'd9},
    {2'd1, 2'd1, 32'd7, 32'd3},
    {2'd2, 2'd2, 32'd3, 32'd0},
    {2'd2, 2'd2, 32'd5, 32'd0},
    {2'd3, 2'd3, 32'd0, 32'd0},
    {2'd3, 2'd3, 32'd0, 32'd0},
    {2'd2, 2'd0, 32'd10, 32'd0},
    {2'd1, 2'd0, 32'd11, 32'd0}
  };

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, op_ready;
  logic [1:0] op_kind = '0;
  logic [AW-1:0] op_addr = '0;
  logic [DW-1:0] op_arg_a = '0, op_arg_b = '0;
  logic [TW-1:0] op_dst = '0;
  logic wb_empty = 1;
  logic resp_valid;
  logic [DW-1:0] resp_old;
  logic [TW-1:0] resp_dst;
  logic getm_valid, evict_dirty;
  logic [AW-1:0] getm_addr, evict_addr;
  logic [DW-1:0] evict_data;
  logic grant_valid = 0;
  logic [DW-1:0] grant_data = '0;
  logic snp_valid = 0, snp_ready, snp_getm = 0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_ack, snp_dirty;
  logic [DW-1:0] snp_data;

  int total = 0, bad = 0;
  logic [DW-1:0] mem [4];
  logic [DW-1:0] gval [4];
  logic held_m = 0;
  int held_addr = 0;
  int tagc = 0;

  always #10 clk = ~clk;

  atomic_rmw_unit #(.AW(AW), .DW(DW), .TW(TW)) u_atomic_rmw_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_addr(op_addr), .op_arg_a(op_arg_a), .op_arg_b(op_arg_b),
    .op_dst(op_dst), .wb_empty(wb_empty), .resp_valid(resp_valid),
    .resp_old(resp_old), .resp_dst(resp_dst), .getm_valid(getm_valid),
    .getm_addr(getm_addr), .evict_dirty(evict_dirty), .evict_addr(evict_addr),
    .evict_data(evict_data), .grant_valid(grant_valid), .grant_data(grant_data),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_getm(snp_getm),
    .snp_addr(snp_addr), .snp_ack(snp_ack), .snp_dirty(snp_dirty),
    .snp_data(snp_data)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string kind_req(input logic [1:0] k);
    case (k)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic do_op(input logic [1:0] kind, input int addr, input logic [DW-1:0] a,
                       input logic [DW-1:0] b, input int hold, input int snp_at,
                       input logic snp_gm);
    logic exp_getm, saw_getm, done, drain_bad, lock_bad, snp_pend;
    logic [DW-1:0] exp_old, exp_new, got_old;
    logic [TW-1:0] dst, got_dst;
    int lat;
    exp_getm = !(held_m && held_addr == addr);
    exp_old = gval[addr];
    case (kind)
      2'd0: exp_new = 1;
      2'd1: exp_new = (exp_old == a) ? b : exp_old;
      2'd2: exp_new = exp_old + a;
      default: exp_new = exp_old;
    endcase
    tagc++;
    dst = TW'(tagc);
    @(negedge clk);
    op_valid = 1; op_kind = kind; op_addr = AW'(addr);
    op_arg_a = a; op_arg_b = b; op_dst = dst;
    if (hold > 0) wb_empty = 0;
    @(negedge clk);
    op_valid = 0;
    lat = 1; done = 0; saw_getm = 0; drain_bad = 0; lock_bad = 0; snp_pend = 0;
    got_old = '0; got_dst = '0;
    while (!done && lat < 100) begin
      grant_valid = 0;
      wb_empty = (lat > hold);
      if (lat <= hold && (getm_valid || resp_valid)) drain_bad = 1;
      if (snp_at == lat) begin
        snp_valid = 1; snp_getm = snp_gm; snp_addr = AW'(addr); snp_pend = 1;
      end
      if (snp_pend && !resp_valid && snp_ready) lock_bad = 1;
      if (resp_valid) begin
        done = 1; got_old = resp_old; got_dst = resp_dst;
      end else if (getm_valid) begin
        saw_getm = 1;
        chk(getm_addr == AW'(addr), "R6", "getm address", 64'(getm_addr), 64'(addr));
        if (evict_dirty) begin
          chk(evict_data == gval[evict_addr[1:0]], "R6", "victim data",
              64'(evict_data), 64'(gval[evict_addr[1:0]]));
          mem[evict_addr[1:0]] = evict_data;
        end
        grant_valid = 1;
        grant_data = mem[addr];
      end
      if (!done) begin
        @(negedge clk);
        lat++;
      end
    end
    chk(done, "R9", "response seen", 64'(done), 64'd1);
    chk(got_old == exp_old, kind_req(kind), "old value", 64'(got_old), 64'(exp_old));
    chk(got_dst == dst, "R9", "destination tag", 64'(got_dst), 64'(dst));
    chk(saw_getm == exp_getm, "R6", "getm issued", 64'(saw_getm), 64'(exp_getm));
    if (hold > 0) chk(!drain_bad, "R5", "activity while draining", 64'(drain_bad), 64'd0);
    if (!exp_getm) chk(lat == 5 + hold, "R10", "hit latency", 64'(lat), 64'(5 + hold));
    gval[addr] = exp_new;
    held_m = 1; held_addr = addr;
    if (snp_at > 0) begin
      chk(!lock_bad, "R7", "request taken inside lock", 64'(lock_bad), 64'd0);
      chk(snp_ready, "R7", "ready in respond cycle", 64'(snp_ready), 64'd1);
      @(negedge clk);
      snp_valid = 0;
      chk(snp_ack, "R8", "held request answered", 64'(snp_ack), 64'd1);
      chk(snp_dirty, "R8", "held request dirty", 64'(snp_dirty), 64'd1);
      chk(snp_data == exp_new, "R8", "data after write", 64'(snp_data), 64'(exp_new));
      mem[addr] = snp_data;
      held_m = 0;
    end
  endtask

  task automatic snoop_idle(input logic gm, input int addr);
    logic exp_dirty;
    exp_dirty = held_m && held_addr == addr;
    @(negedge clk);
    snp_valid = 1; snp_getm = gm; snp_addr = AW'(addr);
    chk(snp_ready, "R8", "ready when idle", 64'(snp_ready), 64'd1);
    @(negedge clk);
    snp_valid = 0;
    chk(snp_ack, "R8", "idle request answered", 64'(snp_ack), 64'd1);
    chk(snp_dirty == exp_dirty, "R8", "idle dirty flag", 64'(snp_dirty), 64'(exp_dirty));
    if (exp_dirty) begin
      chk(snp_data == gval[addr], "R8", "idle data", 64'(snp_data), 64'(gval[addr]));
      mem[addr] = snp_data;
    end
    if (held_addr == addr) held_m = 0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mem[0] = 32'd0; mem[1] = 32'd7; mem[2] = 32'hFFFF_FFFE; mem[3] = 32'd42;
    for (int i = 0; i < 4; i++) gval[i] = mem[i];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(op_ready, "R11", "op_ready", 64'(op_ready), 64'd1);
    chk(!resp_valid, "R11", "resp_valid", 64'(resp_valid), 64'd0);
    chk(!getm_valid, "R11", "getm_valid", 64'(getm_valid), 64'd0);
    chk(!snp_ack, "R11", "snp_ack", 64'(snp_ack), 64'd0);

    for (int v = 0; v < NV; v++)
      do_op(VECS[v][67:66], int'(VECS[v][65:64]), VECS[v][63:32], VECS[v][31:0], 0, 0, 1'b0);

    // R5 and R10: drain held four cycles on a hit
    do_op(2'd2, 0, 32'd1, 32'd0, 4, 0, 1'b0);
    // R7: GetS arriving during the operation waits for the write
    do_op(2'd0, 0, 32'd0, 32'd0, 0, 2, 1'b0);
    // R6: S is not enough to write, GetM needed
    do_op(2'd1, 0, 32'd1, 32'd5, 0, 0, 1'b0);
    // R8: unrelated request leaves the line in M
    snoop_idle(1'b0, 2);
    do_op(2'd2, 0, 32'd0, 32'd0, 0, 0, 1'b0);
    // R8: GetM invalidates, another agent then writes
    snoop_idle(1'b1, 0);
    gval[0] = gval[0] + 32'd100;
    mem[0] = gval[0];
    do_op(2'd2, 0, 32'd1, 32'd0, 0, 0, 1'b0);
    // R9: idle again
    @(negedge clk);
    chk(op_ready && !resp_valid, "R9", "idle after response", 64'(op_ready), 64'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule